// File: doc/BRIEF.md
# Program run-time stopwatch

This block times how long an interpreted program runs, with one millisecond resolution. It watches the interpreter's current line number and its run-mode flag, and on each pulse of a roughly 1 kHz tick enable it advances a milliseconds field that runs from 0 to 999 and carries into a seconds field. The counters stop when the program leaves run mode, so a display can read the elapsed time after the program has finished.

No explicit start command exists. On every tick the block keeps a delayed copy of the line number. A tick in run mode that finds that copy at zero clears both fields, so the count restarts each time a program starts executing from the idle state.

Top module: `run_stopwatch`

## Requirements
- R1: An asserted asynchronous reset clears both count fields and the delayed line-number copy, so the first run-mode tick after reset is a clearing tick even when the line number is nonzero.
- R2: The delayed line-number copy loads the line number only on a cycle with the tick enable high; line changes between ticks are not captured.
- R3: A tick in run mode while the delayed copy equals zero sets both the milliseconds and the seconds field to zero.
- R4: A tick in run mode while the delayed copy is nonzero and milliseconds is below 999 raises milliseconds by one and leaves seconds unchanged.
- R5: A tick in run mode while the delayed copy is nonzero and milliseconds equals 999 sets milliseconds to 0 and raises seconds by one; milliseconds never exceeds 999.
- R6: With run mode low, ticks leave both count fields unchanged, while the delayed copy is still loaded.
- R7: On a cycle with the tick enable low, both count fields keep their values.
- R8: The seconds field is SEC_W bits wide (16 by default) and wraps from its all-ones value to zero with no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| tick_en | input | 1 | One-cycle pulse, about once per millisecond |
| line_num | input | LINE_W (16) | Current program line number, zero when idle |
| run_mode | input | 1 | High while the interpreter executes a program |
| ms_count | output | MS_W (10) | Milliseconds field, 0 to 999 |
| sec_count | output | SEC_W (16) | Seconds field |

## Verification
The assertions take the tick enable to be a single-cycle pulse in the system clock domain and the line number and run flag to be synchronous to that clock, so every count step is checked one cycle after the qualifying tick. The bench drives all inputs on the falling edge, keeps ticks one cycle wide with idle gaps or back-to-back, and builds the bench instance with a four-bit seconds field so that the seconds wrap is reached in a short run. A mid-run reset with a nonzero line number shows that the delayed copy was cleared.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;

  // Milliseconds step: returns the next value within a modulus of limit.
  function automatic int unsigned ms_step(input int unsigned ms, input int unsigned limit);
    return (ms + 1 >= limit) ? 0 : ms + 1;
  endfunction

  // True when the milliseconds value is the last one before wrapping.
  function automatic logic ms_at_top(input int unsigned ms, input int unsigned limit);
    return (ms + 1 == limit);
  endfunction

endpackage

// File: rtl/sw_line_tracker.sv
module sw_line_tracker #(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [LINE_W-1:0] line_num,
  output logic              line_was_zero
);
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          line_q <= '0;
    else if (tick_en) line_q <= line_num;
  end

  assign line_was_zero = (line_q == '0);
endmodule

// File: rtl/sw_ms_counter.sv
module sw_ms_counter
  import stopwatch_pkg::*;
#(
  parameter int MS_LIMIT = 1000,
  parameter int MS_W     = $clog2(MS_LIMIT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_en,
  input  logic            step_en,
  output logic [MS_W-1:0] ms_q,
  output logic            wrap_en
);
  logic [MS_W-1:0] ms_nxt;

  always_comb begin
    ms_nxt  = MS_W'(ms_step(int'(ms_q), MS_LIMIT));
    wrap_en = step_en & ms_at_top(int'(ms_q), MS_LIMIT);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          ms_q <= '0;
    else if (clr_en)  ms_q <= '0;
    else if (step_en) ms_q <= ms_nxt;
  end
endmodule

// File: rtl/sw_sec_counter.sv
module sw_sec_counter #(
  parameter int SEC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic             inc_en,
  output logic [SEC_W-1:0] sec_q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)         sec_q <= '0;
    else if (clr_en) sec_q <= '0;
    else if (inc_en) sec_q <= sec_q + 1'b1;
  end
endmodule

// File: rtl/run_stopwatch.sv
module run_stopwatch #(
  parameter int LINE_W   = 16,
  parameter int MS_LIMIT = 1000,
  parameter int SEC_W    = 16,
  localparam int MS_W    = $clog2(MS_LIMIT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [LINE_W-1:0] line_num,
  input  logic              run_mode,
  output logic [MS_W-1:0]   ms_count,
  output logic [SEC_W-1:0]  sec_count
);
  // Named internal events, visible to the checker
  logic line_was_zero;
  logic restart_ev;
  logic step_ev;
  logic carry_ev;

  sw_line_tracker #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .line_num(line_num), .line_was_zero(line_was_zero)
  );

  assign restart_ev = tick_en & run_mode & line_was_zero;
  assign step_ev    = tick_en & run_mode & ~line_was_zero;

  sw_ms_counter #(.MS_LIMIT(MS_LIMIT), .MS_W(MS_W)) u_ms (
    .clk(clk), .rst(rst), .clr_en(restart_ev), .step_en(step_ev),
    .ms_q(ms_count), .wrap_en(carry_ev)
  );

  sw_sec_counter #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst(rst), .clr_en(restart_ev), .inc_en(carry_ev),
    .sec_q(sec_count)
  );
endmodule

// File: rtl/run_stopwatch_chk.sv
module run_stopwatch_chk #(
  parameter int MS_LIMIT = 1000,
  parameter int SEC_W    = 16,
  parameter int MS_W     = $clog2(MS_LIMIT)
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             run_mode,
  input logic             line_was_zero,
  input logic [MS_W-1:0]  ms_count,
  input logic [SEC_W-1:0] sec_count
);
  localparam logic [MS_W-1:0] TOP = MS_W'(MS_LIMIT - 1);

  a_r3_restart_clears: assert property (@(posedge clk) disable iff (rst)
    (tick_en && run_mode && line_was_zero) |=> (ms_count == '0 && sec_count == '0));

  a_r4_ms_step: assert property (@(posedge clk) disable iff (rst)
    (tick_en && run_mode && !line_was_zero && ms_count != TOP)
      |=> (ms_count == $past(ms_count) + 1'b1 && $stable(sec_count)));

  a_r5_wrap_carry: assert property (@(posedge clk) disable iff (rst)
    (tick_en && run_mode && !line_was_zero && ms_count == TOP)
      |=> (ms_count == '0 && sec_count == SEC_W'($past(sec_count) + 1'b1)));

  a_r5_ms_range: assert property (@(posedge clk) disable iff (rst)
    ms_count <= TOP);

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !run_mode) |=> ($stable(ms_count) && $stable(sec_count)));

  a_r7_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> ($stable(ms_count) && $stable(sec_count)));
endmodule

bind run_stopwatch run_stopwatch_chk #(.MS_LIMIT(MS_LIMIT), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .run_mode(run_mode),
  .line_was_zero(line_was_zero), .ms_count(ms_count), .sec_count(sec_count)
);

// File: tb/run_stopwatch_bench.sv
`timescale 1ns/1ps
module run_stopwatch_bench;
  localparam int SEC_W = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [15:0] line_num = '0;
  logic        run_mode = 1'b0;
  logic [9:0]  ms_count;
  logic [SEC_W-1:0] sec_count;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  int m_ms = 0, m_sec = 0, m_line = 0;

  always #5 clk = ~clk;

  run_stopwatch #(.SEC_W(SEC_W)) u_run_stopwatch (
    .clk(clk), .rst(rst), .tick_en(tick_en), .line_num(line_num),
    .run_mode(run_mode), .ms_count(ms_count), .sec_count(sec_count)
  );

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_ms = 0; m_sec = 0; m_line = 0;
    end else if (tick_en) begin
      if (run_mode) begin
        if (m_line == 0) begin
          m_ms = 0; m_sec = 0;
        end else begin
          m_ms = m_ms + 1;
          if (m_ms == 1000) begin
            m_ms = 0;
            m_sec = (m_sec + 1) % (1 << SEC_W);
          end
        end
      end
      m_line = int'(line_num);
    end
  end

  always @(negedge clk) begin
    #1;
    compared++;
    if (int'(ms_count) != m_ms || int'(sec_count) != m_sec) begin
      mismatched++;
      $display("FAIL %s: actual ms=%0d sec=%0d expected ms=%0d sec=%0d",
               tag, ms_count, sec_count, m_ms, m_sec);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic expect_now(input string r, input int ms, input int sec);
    #2;
    compared++;
    if (int'(ms_count) != ms || int'(sec_count) != sec) begin
      mismatched++;
      $display("FAIL %s: actual ms=%0d sec=%0d expected ms=%0d sec=%0d",
               r, ms_count, sec_count, ms, sec);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R1", 0, 0);
    rst = 1'b0;
    // R7: no ticks, nothing moves
    tag = "R7"; run_mode = 1'b1; line_num = 16'd5;
    repeat (10) @(negedge clk);
    // R3 then R4: first tick clears, later ticks step
    tag = "R3"; ticks(1, 2);
    expect_now("R3", 0, 0);
    tag = "R4"; ticks(20, 2);
    expect_now("R4", 20, 0);
    // R5: cross the 999 boundary
    tag = "R5"; ticks(985, 0);
    expect_now("R5", 5, 1);
    // R6: idle ticks with changing line numbers
    tag = "R6"; run_mode = 1'b0;
    for (int k = 0; k < 6; k++) begin line_num = 16'(k * 3); ticks(1, 1); end
    line_num = 16'd9; ticks(1, 1);
    expect_now("R6", 5, 1);
    // R2: zero between ticks is not captured
    tag = "R2"; run_mode = 1'b1; line_num = 16'd0;
    @(negedge clk); line_num = 16'd7; @(negedge clk);
    ticks(1, 1);
    expect_now("R2", 6, 1);
    line_num = 16'd0; ticks(1, 1);
    expect_now("R2", 7, 1);
    tag = "R3"; line_num = 16'd12; ticks(1, 1);
    expect_now("R3", 0, 0);
    // R1: mid-run reset clears the delayed copy
    ticks(50, 0);
    tag = "R1"; rst = 1'b1; @(negedge clk);
    expect_now("R1", 0, 0);
    rst = 1'b0; @(negedge clk);
    ticks(1, 1);
    expect_now("R1", 0, 0);
    ticks(3, 0);
    expect_now("R1", 3, 0);
    // R8: seconds wrap
    tag = "R8"; ticks(16000, 0);
    expect_now("R8", 3, 0);
    ticks(997, 0);
    expect_now("R5", 0, 1);
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule